// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor request port and a slow word-wide main-memory port. Each slot holds a valid flag, a tag and one data word. The low address bits select a byte inside the word and are ignored. The next `IDX_W` bits pick the slot. The remaining upper bits form the tag. A read that finds a valid slot with a matching tag completes in the same cycle. A read that misses holds the processor off while the word is fetched from memory and written into the slot. The processor keeps presenting the same read, and that read then completes as a hit in the cycle after the memory acknowledge.

A store does not look at the slot's contents. It overwrites the data and tag of the indexed slot, marks the slot valid, and always writes the same word to main memory. The store completes in the cycle the memory acknowledges that write.

The processor side uses valid/ready. While `cpu_valid` is high and `cpu_ready` is low, the processor must hold `cpu_we`, `cpu_addr` and `cpu_wdata` unchanged. A request is accepted on the rising edge where both signals are high. Because of this rule, a store that follows a read cannot start while that read's refill is still outstanding. The memory side uses req/ack. `mem_req` and its word address, direction and write data stay unchanged until `mem_ack` is sampled high. Only one memory transaction is in flight at a time.

The default geometry is a 32-bit address and 256 slots. `IDX_W` can be set from 14 down to 2. The bench uses a 4-slot cache on an 8-bit address so that slot conflicts are easy to provoke.

Top module: `wt_dcache`

## Requirements
- R1: A byte address splits into offset bits [OFF_W-1:0], which are ignored, index bits [OFF_W+IDX_W-1:OFF_W], and tag bits [ADDR_W-1:OFF_W+IDX_W]. Two byte addresses inside one word hit the same slot. An address that matches the index but differs in the tag misses.
- R2: A read hits only when the indexed slot is valid and its stored tag equals the address tag. On a hit, `cpu_hit` and `cpu_ready` are high in the cycle of presentation, `cpu_rdata` is the stored word, and no memory transaction starts.
- R3: Reset clears every valid flag, so the first read of any address after reset misses. Straight after reset, `cpu_ready` and `mem_req` are low.
- R4: A store raises `mem_req` with `mem_we`=1, the word address `cpu_addr[ADDR_W-1:OFF_W]` and the store data, and raises `cpu_ready` in the cycle of `mem_ack`. The slot is written without a hit check, so it replaces whatever tag it held. A later read of that address hits and returns the stored word.
- R5: A read miss keeps `cpu_ready` low and raises `mem_req` with `mem_we`=0 in the next cycle. The slot is filled from `mem_rdata` on the acknowledge. The re-presented read hits with that word one cycle after `mem_ack`, so a miss served with an L-cycle memory latency takes L+1 cycles.
- R6: Addresses that share an index evict each other. With word addresses and 4 slots, the read sequence 3, 8, 3, 2, 4, 8 gives miss, miss, hit, miss, miss, miss.
- R7: Once raised, `mem_req` stays high with a stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when a load is accepted |
| cpu_hit | output | 1 | Presented load matches a valid slot |
| mem_req | output | 1 | Memory transaction request |
| mem_ack | input | 1 | Memory completes the transaction |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W-OFF_W | Word address |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |

## Verification
A stale valid flag or a wrong tag comparison shows up as a wrong `cpu_hit` on the very first cycle a read is presented. The conflict sequence and the store-overwrite cases are built to expose exactly that. A wrong fill path shows up as wrong `cpu_rdata` in the cycle after the acknowledge. A broken write-through stays hidden until the slot is evicted and re-read from memory, so the bench forces that eviction on purpose. A mis-sequenced controller changes the number of stall cycles, or the `mem_addr` held during the wait, within the same transaction.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/wt_dcache_slots.sv
module wt_dcache_slots #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0]  vld_vec;
  logic [TAG_W-1:0]  tag_mem [SLOTS];
  logic [DATA_W-1:0] dat_mem [SLOTS];

  // one flag per slot, cleared by reset, set on any write into the slot
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                v_q <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(s)))   v_q <= 1'b1;
    end
    assign vld_vec[s] = v_q;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      dat_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = vld_vec[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = dat_mem[rd_idx];
endmodule

// File: rtl/wt_dcache_lookup.sv
module wt_dcache_lookup #(
  parameter int TAG_W = 22
) (
  input  logic             slot_valid,
  input  logic [TAG_W-1:0] slot_tag,
  input  logic [TAG_W-1:0] req_tag,
  output logic             match
);
  assign match = slot_valid && (slot_tag == req_tag);
endmodule

// File: rtl/wt_dcache_ctrl.sv
module wt_dcache_ctrl
  import wt_dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_valid,
  input  logic                       cpu_we,
  input  logic [ADDR_W-OFF_W-1:0]    cpu_waddr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  input  logic                       lookup_hit,
  output logic                       cpu_ready,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-OFF_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic                       mem_ack,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic                       fill_en,
  output logic [IDX_W-1:0]           fill_idx,
  output logic [ADDR_W-OFF_W-IDX_W-1:0] fill_tag,
  output logic [DATA_W-1:0]          fill_data
);
  localparam int WADDR_W = ADDR_W - OFF_W;

  ctl_state_e         state_q, state_d;
  logic [WADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0]  data_q, data_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    data_d  = data_q;
    case (state_q)
      ST_IDLE: begin
        if (cpu_valid) begin
          if (cpu_we) begin
            state_d = ST_WRITE;
            addr_d  = cpu_waddr;
            data_d  = cpu_wdata;
          end else if (!lookup_hit) begin
            state_d = ST_FILL;
            addr_d  = cpu_waddr;
          end
        end
      end
      ST_FILL, ST_WRITE: begin
        if (mem_ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  assign cpu_ready = ((state_q == ST_IDLE) && cpu_valid && !cpu_we && lookup_hit) ||
                     ((state_q == ST_WRITE) && mem_ack);

  assign fill_en   = mem_req && mem_ack;
  assign fill_idx  = addr_q[IDX_W-1:0];
  assign fill_tag  = addr_q[WADDR_W-1:IDX_W];
  assign fill_data = (state_q == ST_FILL) ? mem_rdata : data_q;
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_valid,
  output logic                    cpu_ready,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_hit,
  output logic                    mem_req,
  input  logic                    mem_ack,
  output logic                    mem_we,
  output logic [ADDR_W-OFF_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata
);
  localparam int WADDR_W = ADDR_W - OFF_W;
  localparam int TAG_W   = WADDR_W - IDX_W;

  logic [WADDR_W-1:0] req_waddr;
  logic [IDX_W-1:0]   req_idx;
  logic [TAG_W-1:0]   req_tag;
  logic               slot_valid, lookup_hit, fill_en;
  logic [TAG_W-1:0]   slot_tag, fill_tag;
  logic [IDX_W-1:0]   fill_idx;
  logic [DATA_W-1:0]  fill_data;

  assign req_waddr = cpu_addr[ADDR_W-1:OFF_W];
  assign req_idx   = req_waddr[IDX_W-1:0];
  assign req_tag   = req_waddr[WADDR_W-1:IDX_W];

  wt_dcache_slots #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_valid (slot_valid),
    .rd_tag   (slot_tag),
    .rd_data  (cpu_rdata),
    .wr_en    (fill_en),
    .wr_idx   (fill_idx),
    .wr_tag   (fill_tag),
    .wr_data  (fill_data)
  );

  wt_dcache_lookup #(.TAG_W(TAG_W)) u_lookup (
    .slot_valid (slot_valid),
    .slot_tag   (slot_tag),
    .req_tag    (req_tag),
    .match      (lookup_hit)
  );

  wt_dcache_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_we     (cpu_we),
    .cpu_waddr  (req_waddr),
    .cpu_wdata  (cpu_wdata),
    .lookup_hit (lookup_hit),
    .cpu_ready  (cpu_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .fill_tag   (fill_tag),
    .fill_data  (fill_data)
  );

  assign cpu_hit = cpu_valid && !cpu_we && lookup_hit;
endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_valid,
  input logic                    cpu_ready,
  input logic                    cpu_we,
  input logic [ADDR_W-1:0]       cpu_addr,
  input logic [DATA_W-1:0]       cpu_wdata,
  input logic [DATA_W-1:0]       cpu_rdata,
  input logic                    cpu_hit,
  input logic                    mem_req,
  input logic                    mem_ack,
  input logic                    mem_we,
  input logic [ADDR_W-OFF_W-1:0] mem_addr,
  input logic [DATA_W-1:0]       mem_wdata,
  input logic [DATA_W-1:0]       mem_rdata
);
  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R7

  AST_STORE_WRITES_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_we && cpu_ready |-> mem_req && mem_we && mem_ack &&
      (mem_wdata == cpu_wdata) && (mem_addr == cpu_addr[ADDR_W-1:OFF_W])); // R4

  AST_LOAD_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !cpu_we && cpu_ready |-> cpu_hit && !mem_req); // R2

  AST_MISS_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !cpu_we && !cpu_hit && !mem_req |=> mem_req && !mem_we); // R5

  AST_FILL_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack && cpu_valid && !cpu_we
      |=> cpu_ready && cpu_hit && (cpu_rdata == $past(mem_rdata))); // R5

  AST_CPU_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !cpu_ready |=> cpu_valid && $stable(cpu_addr) && $stable(cpu_we)); // R5
endmodule

bind wt_dcache wt_dcache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_ready (cpu_ready),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rdata (cpu_rdata),
  .cpu_hit   (cpu_hit),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata)
);

// File: tb/wt_dcache_tb.sv
`timescale 1ns/1ps
module wt_dcache_tb;
  localparam int ADDR_W = 8;
  localparam int OFF_W  = 2;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 32;
  localparam int WA_W   = ADDR_W - OFF_W;
  localparam int NVEC   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_hit, mem_req, mem_we;
  logic [DATA_W-1:0] cpu_rdata, mem_wdata;
  logic [WA_W-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  int errors = 0, checks = 0;
  int lat = 2, cnt = 0, ntx = 0;
  logic [DATA_W-1:0] model [64];
  logic [DATA_W-1:0] shadow [64];
  logic [WA_W-1:0]   last_wa = '0;
  logic [DATA_W-1:0] last_wd = '0;

  always #4 clk = ~clk;

  wt_dcache #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory responder: acknowledges after lat falling edges of a held request
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      cnt = 0;
    end else if (mem_req && !mem_ack) begin
      cnt++;
      if (cnt >= lat) begin
        cnt = 0;
        mem_ack = 1'b1;
        ntx++;
        if (mem_we) begin
          model[mem_addr] = mem_wdata;
          last_wa = mem_addr;
          last_wd = mem_wdata;
        end else begin
          mem_rdata = model[mem_addr];
        end
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [WA_W-1:0] wa, input logic [1:0] boff,
                     input logic [DATA_W-1:0] wd, output logic first_hit,
                     output logic [DATA_W-1:0] rd, output int cyc, output int reqc,
                     output int badaddr);
    @(negedge clk);
    cpu_valid = 1'b1;
    cpu_we    = we;
    cpu_addr  = {wa, boff};
    cpu_wdata = wd;
    cyc = 0; reqc = 0; badaddr = 0;
    #1;
    first_hit = cpu_hit;
    while (!cpu_ready && cyc < 200) begin
      @(negedge clk);
      #1;
      cyc++;
      if (mem_req) begin
        reqc++;
        if (mem_addr !== wa) badaddr++;
      end
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_valid = 1'b0;
    cpu_we    = 1'b0;
    if (we) shadow[wa] = wd;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  // {we, word address, store data, expected first-cycle hit}
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b0, 6'd3, 32'h0,          1'b0},
    {1'b0, 6'd8, 32'h0,          1'b0},
    {1'b0, 6'd3, 32'h0,          1'b1},
    {1'b0, 6'd2, 32'h0,          1'b0},
    {1'b0, 6'd4, 32'h0,          1'b0},
    {1'b0, 6'd8, 32'h0,          1'b0},
    {1'b1, 6'd5, 32'hC0DE_0005,  1'b0},
    {1'b0, 6'd5, 32'h0,          1'b1},
    {1'b1, 6'd9, 32'hBEEF_0009,  1'b0},
    {1'b0, 6'd9, 32'h0,          1'b1},
    {1'b0, 6'd5, 32'h0,          1'b0},
    {1'b0, 6'd3, 32'h0,          1'b1}
  };

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic fh;
    logic [DATA_W-1:0] rd;
    int cyc, reqc, bad, tx0;

    for (int i = 0; i < 64; i++) begin
      model[i]  = 32'h5A00_0000 | DATA_W'(i);
      shadow[i] = 32'h5A00_0000 | DATA_W'(i);
    end
    do_reset();
    @(negedge clk);
    #1;
    chk("R3 ready after reset", 32'(cpu_ready), 32'd0);
    chk("R3 mem_req after reset", 32'(mem_req), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      logic we;
      logic [WA_W-1:0] wa;
      logic [DATA_W-1:0] wd;
      logic eh;
      we = VEC[v][39];
      wa = VEC[v][38:33];
      wd = VEC[v][32:1];
      eh = VEC[v][0];
      tx0 = ntx;
      acc(we, wa, 2'b00, wd, fh, rd, cyc, reqc, bad);
      if (we) begin
        chk("R4 write-through addr", 32'(last_wa), 32'(wa));
        chk("R4 write-through data", last_wd, wd);
        chk("R4 store waits for ack", 32'(cyc), 32'(lat));
      end else begin
        chk("R6 first-cycle hit", 32'(fh), 32'(eh));
        chk("R2 load data", rd, shadow[wa]);
        if (eh) chk("R2 no memory access on hit", 32'(ntx - tx0), 32'd0);
        else    chk("R5 miss stall length", 32'(cyc), 32'(lat + 1));
      end
    end

    // R1: byte offset ignored, tag bits compared
    acc(1'b0, 6'd8, 2'b11, '0, fh, rd, cyc, reqc, bad);
    chk("R1 offset ignored hit", 32'(fh), 32'd1);
    chk("R1 offset ignored data", rd, shadow[8]);
    acc(1'b0, 6'd24, 2'b00, '0, fh, rd, cyc, reqc, bad);
    chk("R1 tag mismatch misses", 32'(fh), 32'd0);
    chk("R1 refill data", rd, shadow[24]);

    // R7: long latency, request held stable
    lat = 5;
    acc(1'b0, 6'd40, 2'b01, '0, fh, rd, cyc, reqc, bad);
    chk("R7 request cycles", 32'(reqc), 32'd5);
    chk("R7 address stable", 32'(bad), 32'd0);
    chk("R5 long miss stall", 32'(cyc), 32'd6);
    chk("R5 long miss data", rd, shadow[40]);

    // R3: reset invalidates cached slots
    lat = 1;
    do_reset();
    acc(1'b0, 6'd40, 2'b00, '0, fh, rd, cyc, reqc, bad);
    chk("R3 miss after reset", 32'(fh), 32'd0);
    chk("R3 data after reset", rd, shadow[40]);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule